// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block holds the digital timing side of a 512-pixel line-scan image sensor. A single start pulse sampled on a rising clock edge opens an output period. During that period the block presents one pixel index per clock, together with a test-pattern pixel value and an output-enable. The output-enable stands in for the analog output being driven rather than floating. A token runs down a 512-stage shift register. When it reaches the far end, a one-cycle serial-out pulse appears, and that pulse can start the next sensor in a chain.

A period always runs to completion. Once started, it lasts a fixed 513 rising edges, and any start pulse that arrives before then has no effect. After the 513th edge the block is idle. A start pulse on the very next edge (the 514th) opens a new period at once, which gives the shortest possible integration time. Two phase signals follow the clock every cycle. One is a sense-node reset strobe, high while the clock is low. The other is a sample/hold indicator, which samples while the clock is high.

Top module: `lsr_readout_top`

## Requirements
- R1: A synchronous active-high `rst` clears the shift register and the pixel index and deasserts `oe`, taking priority over `si` on the same edge; after it `oe`=0, `pix_idx`=0, `so`=0.
- R2: While idle, `si` high at a rising edge starts a period: after that edge `oe`=1 and `pix_idx`=0. While idle with `si` low, `oe` stays 0.
- R3: While `oe`=1 and `pix_idx` is below 511, each rising edge advances `pix_idx` by exactly one.
- R4: `so` is high for exactly one cycle, following the 512th edge of a period, while `pix_idx`=511; it is low at all other times.
- R5: The 513th edge of a period deasserts `oe` and returns `pix_idx` to 0.
- R6: `si` high on any edge from the 2nd through the 513th of a period is ignored: the index keeps counting and the period end does not move.
- R7: `si` high on the 514th edge (the first edge after the period ends) starts a new period immediately, with `oe`=1 and `pix_idx`=0.
- R8: `smp_hold` equals 1 while `clk` is high and 0 while it is low; `pix_rst` is its complement, so the two are never high together.
- R9: With the default ramp pattern, `pix_val` equals `pix_idx` while `oe`=1 and is 0 while `oe`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| si | input | 1 | Serial start pulse |
| so | output | 1 | Cascade pulse for the next sensor's start input |
| oe | output | 1 | Output driven (0 models high impedance) |
| pix_idx | output | 9 | Index of the pixel currently presented |
| pix_val | output | 9 | Test-pattern pixel value |
| pix_rst | output | 1 | Sense-node reset strobe (clock low phase) |
| smp_hold | output | 1 | Sample (1) / hold (0) indicator |

## Verification
The embedded assertions check these rules on every clock: the index advances by one per edge, an accepted start opens a period at index 0, the period ends after index 511, and the cascade pulse lasts a single cycle and coincides with the last index. Whether the period lasts exactly 513 edges, and whether a start pulse inside the period is truly ignored, is shown by the bench's scenarios. These scenarios include start pulses mid-period and on edge 513, a back-to-back restart on edge 514, and a reset issued during a period together with a start pulse. The phase signals and the test-pattern value are also compared against their expected values by the bench on every cycle.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_READ = 1'b1
    } phase_e;

    localparam int PAT_RAMP    = 0;
    localparam int PAT_CHECKER = 1;

endpackage

// File: rtl/lsr_period_ctrl.sv
module lsr_period_ctrl #(
    parameter int NPIX = 512,
    parameter int IDXW = $clog2(NPIX)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            si,
    output logic            start,
    output logic            oe,
    output logic [IDXW-1:0] idx
);
    import lsr_pkg::*;

    localparam logic [IDXW-1:0] LAST = IDXW'(NPIX - 1);

    typedef struct packed {
        phase_e          ph;
        logic [IDXW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  start_d;

    always_comb begin
        st_d    = st_q;
        start_d = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (si) begin
                    st_d.ph  = PH_READ;
                    st_d.cnt = '0;
                    start_d  = 1'b1;
                end
            end
            PH_READ: begin
                if (st_q.cnt == LAST) begin
                    st_d.ph  = PH_IDLE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d = '{ph: PH_IDLE, cnt: '0};
        endcase
        if (rst) begin
            st_d    = '{ph: PH_IDLE, cnt: '0};
            start_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign start = start_d;
    assign oe    = (st_q.ph == PH_READ);
    assign idx   = st_q.cnt;

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (!oe && si) |=> (oe && idx == '0)); // R2

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (oe && idx != LAST) |=> (oe && idx == ($past(idx) + 1'b1))); // R3

    AST_PERIOD_END: assert property (@(posedge clk) disable iff (rst)
        (oe && idx == LAST) |=> (!oe && idx == '0)); // R5

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (oe && si && idx != LAST) |=> (idx != '0)); // R6

endmodule

// File: rtl/lsr_shift_chain.sv
module lsr_shift_chain #(
    parameter int NPIX = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic so
);

    typedef struct packed {
        logic [NPIX-1:0] sr;
    } chain_t;

    chain_t ch_d, ch_q;

    always_comb begin
        ch_d.sr = {ch_q.sr[NPIX-2:0], start};
        if (rst) begin
            ch_d.sr = '0;
        end
    end

    always_ff @(posedge clk) begin
        ch_q <= ch_d;
    end

    assign so = ch_q.sr[NPIX-1];

    AST_SO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        so |=> !so); // R4

endmodule

// File: rtl/lsr_phase_gen.sv
module lsr_phase_gen (
    input  logic clk,
    output logic pix_rst,
    output logic smp_hold
);

    logic smp_d;

    always_comb begin
        smp_d = clk;
    end

    assign smp_hold = smp_d;
    assign pix_rst  = ~smp_d;

endmodule

// File: rtl/lsr_pattern.sv
module lsr_pattern #(
    parameter int IDXW    = 9,
    parameter int PIXW    = 9,
    parameter int PATTERN = 0
) (
    input  logic            oe,
    input  logic [IDXW-1:0] idx,
    output logic [PIXW-1:0] val
);
    import lsr_pkg::*;

    logic [PIXW-1:0] raw_d;

    generate
        if (PATTERN == PAT_CHECKER) begin : g_checker
            always_comb begin
                raw_d = {PIXW{idx[0]}};
            end
        end else begin : g_ramp
            always_comb begin
                raw_d = PIXW'(idx);
            end
        end
    endgenerate

    always_comb begin
        val = oe ? raw_d : '0;
    end

endmodule

// File: rtl/lsr_readout_top.sv
module lsr_readout_top #(
    parameter int NPIX    = 512,
    parameter int IDXW    = $clog2(NPIX),
    parameter int PIXW    = IDXW,
    parameter int PATTERN = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            si,
    output logic            so,
    output logic            oe,
    output logic [IDXW-1:0] pix_idx,
    output logic [PIXW-1:0] pix_val,
    output logic            pix_rst,
    output logic            smp_hold
);

    localparam logic [IDXW-1:0] LAST = IDXW'(NPIX - 1);

    logic start;

    lsr_period_ctrl #(.NPIX(NPIX), .IDXW(IDXW)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .si    (si),
        .start (start),
        .oe    (oe),
        .idx   (pix_idx)
    );

    lsr_shift_chain #(.NPIX(NPIX)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .so    (so)
    );

    lsr_phase_gen u_phase (
        .clk      (clk),
        .pix_rst  (pix_rst),
        .smp_hold (smp_hold)
    );

    lsr_pattern #(.IDXW(IDXW), .PIXW(PIXW), .PATTERN(PATTERN)) u_pat (
        .oe  (oe),
        .idx (pix_idx),
        .val (pix_val)
    );

    AST_SO_AT_LAST: assert property (@(posedge clk) disable iff (rst)
        so |-> (oe && pix_idx == LAST)); // R4

    AST_LAST_GIVES_SO: assert property (@(posedge clk) disable iff (rst)
        (oe && pix_idx == LAST) |-> so); // R4

endmodule

// File: tb/lsr_readout_top_tb.sv
module lsr_readout_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NPIX       = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       si  = 1'b0;
    logic       so, oe, pix_rst, smp_hold;
    logic [8:0] pix_idx, pix_val;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        bit    oe;
        int    idx;
        bit    so;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    bit m_busy  = 1'b0;
    int m_cnt   = 0;
    bit m_ended = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsr_readout_top u_dut (
        .clk      (clk),
        .rst      (rst),
        .si       (si),
        .so       (so),
        .oe       (oe),
        .pix_idx  (pix_idx),
        .pix_val  (pix_val),
        .pix_rst  (pix_rst),
        .smp_hold (smp_hold)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: applies inputs before an edge and pushes the expected post-edge state
    task automatic step(input bit r, input bit s);
        exp_t  e;
        string tg;
        bit    ended_now;
        @(negedge clk);
        rst = r;
        si  = s;
        ended_now = 1'b0;
        if (r) begin
            m_busy = 1'b0; m_cnt = 0; tg = "R1";
        end else if (!m_busy) begin
            if (s) begin
                m_busy = 1'b1; m_cnt = 0;
                tg = m_ended ? "R7" : "R2";
            end else begin
                tg = "R2";
            end
        end else if (m_cnt == NPIX-1) begin
            m_busy = 1'b0; m_cnt = 0; ended_now = 1'b1; tg = "R5";
        end else begin
            m_cnt++;
            tg = s ? "R6" : ((m_cnt == NPIX-1) ? "R4" : "R3");
        end
        m_ended = ended_now;
        e.oe  = m_busy;
        e.idx = m_cnt;
        e.so  = m_busy && (m_cnt == NPIX-1);
        e.tag = tg;
        exp_q.push_back(e);
    endtask

    // Monitor: compares outputs a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            chk(smp_hold == 1'b1 && pix_rst == 1'b0, "R8", "phase_high",
                {smp_hold, pix_rst}, 2);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(oe == e.oe, e.tag, "oe", oe, e.oe);
                chk(int'(pix_idx) == e.idx, e.tag, "pix_idx", pix_idx, e.idx);
                chk(so == e.so, (e.so || so) ? "R4" : e.tag, "so", so, e.so);
                chk(int'(pix_val) == (e.oe ? e.idx : 0), "R9", "pix_val",
                    pix_val, e.oe ? e.idx : 0);
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            chk(smp_hold == 1'b0 && pix_rst == 1'b1, "R8", "phase_low",
                {smp_hold, pix_rst}, 1);
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL R3 watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        // R2: idle with no start keeps output off
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        // R2: start, then R6 ignored pulses mid-period and on edge 513
        step(1'b0, 1'b1);
        for (int k = 2; k <= 513; k++) step(1'b0, (k >= 100 && k <= 104) || k == 513);
        // R7: restart on edge 514
        step(1'b0, 1'b1);
        for (int k = 2; k <= 513; k++) step(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        // R1: reset mid-period wins over a start pulse
        step(1'b0, 1'b1);
        for (int k = 2; k <= 200; k++) step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0);
        // R4 / R5: full clean period after reset
        step(1'b0, 1'b1);
        for (int k = 2; k <= 513; k++) step(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        chk(exp_q.size() == 0, "R3", "queue_drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule